// File: doc/BRIEF.md
# SATA Port Command-Issue and Soft-Reset Tracker

This block models the command-tracking side of one port of a SATA host bus adapter. It keeps one command-issue bit for each command slot. Host software raises these bits through a write-1-to-set mask. The block clears a bit only once the matching command has been handled, or when a reset sequence asks for it. It also holds the port's task-file data (error and status bytes from the device), the device signature and a record of which slot is busy.

The block runs a two-state machine. In state RUN, commands are accepted. In state RESET, the port is waiting for the second half of a legacy software reset. The transitions are:

- RUN to RESET: an accepted host-to-device register FIS has the SRST bit set in its device-control byte.
- RESET to RUN (soft-reset release): an accepted FIS has SRST clear. This performs a full port reset.
- Any state to RUN (COMRESET): a COMRESET pulse arrives. It performs the same full port reset without touching any particular slot first.
- RUN to RUN (command start): an accepted FIS has SRST clear.
- RESET to RESET (ignored FIS): an accepted FIS still has SRST set.

After any port reset, the first device-to-host register FIS loads the signature. The later ones update only the task-file data.

Top module: `sata_port_tracker`

## Requirements
- R1: A one in bit i of `ci_set` sets command-issue bit i at the next clock edge. Zeros in `ci_set` leave bits unchanged.
- R2: In RUN with no slot busy, a FIS with `h2d_ok`=1 and SRST clear marks `h2d_slot` busy and leaves the command-issue bits unchanged. A later `cmd_done` pulse clears the busy slot's command-issue bit and sets `busy_none`=1. While no slot is busy, `busy_slot` reads all ones.
- R3: A FIS with `h2d_ok`=0 has no effect on the command-issue bits, the state or the busy tracking.
- R4: SRST is bit 2 of `h2d_ctl`. In RUN, an accepted FIS with SRST set moves the port to RESET (`in_reset`=1). It clears its own slot's command-issue bit only if `h2d_clr_busy`=1. Otherwise the bit stays set.
- R5: In RESET, an accepted FIS with SRST clear performs a port reset and returns the port to RUN. The port reset sets command-issue to 0, `tfd` to 0x007F, `sig` to 0xFFFFFFFF, `busy_none` to 1 and `init_d2h_sent` to 0. An accepted FIS with SRST set while in RESET is ignored.
- R6: A `comreset` pulse in either state performs the same port reset and leaves the port in RUN.
- R7: Every `d2h_valid` loads `tfd` = {`d2h_err`, `d2h_status`}. The first one after a port reset also sets `init_d2h_sent` and loads `sig` = {`d2h_lba_hi`, `d2h_lba_mid`, `d2h_sect_num`, `d2h_sect_cnt`} (high cylinder in bits 31:24). Later ones leave `sig` unchanged.
- R8: When a set and a clear hit the same slot in one cycle, the clear wins. This also applies to a port reset.
- R9: With `rst_n` low at a clock edge, all state takes the port-reset values of R5 and the state becomes RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| ci_set | input | NSLOT | Write-1-to-set mask for command-issue bits |
| h2d_valid | input | 1 | Host-to-device register FIS present this cycle |
| h2d_ok | input | 1 | FIS parsed correctly |
| h2d_slot | input | SLOT_W | Command slot of the FIS |
| h2d_ctl | input | 8 | Device-control byte of the FIS |
| h2d_clr_busy | input | 1 | Command-header "clear busy on R_OK" option |
| cmd_done | input | 1 | Busy command has been handled |
| comreset | input | 1 | Port reset request, no slot involved |
| d2h_valid | input | 1 | Device-to-host register FIS present |
| d2h_status | input | 8 | Status byte |
| d2h_err | input | 8 | Error byte |
| d2h_lba_hi | input | 8 | High cylinder byte |
| d2h_lba_mid | input | 8 | Low cylinder byte |
| d2h_sect_num | input | 8 | Sector-number byte |
| d2h_sect_cnt | input | 8 | Sector-count byte |
| ci | output | NSLOT | Command-issue register |
| in_reset | output | 1 | 1 in state RESET |
| tfd | output | 16 | Task-file data {error, status} |
| sig | output | 32 | Device signature |
| busy_none | output | 1 | No slot busy |
| busy_slot | output | SLOT_W | Busy slot, all ones when none |
| init_d2h_sent | output | 1 | First D2H FIS since reset seen |

## Verification
The bench builds the block with its defaults: NSLOT=32, SLOT_W=5 and SRST_BIT=2. These values let it drive slot 31, the top slot. Slot 31 has the same encoding as the all-ones "no slot busy" value, so that corner is exercised. The full 32-bit command-issue register and the signature byte ordering are also within reach.

// File: rtl/sata_port_pkg.sv
package sata_port_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_RESET = 1'b1
    } port_st_e;

    localparam logic [15:0] TFD_RST = 16'h007F;
    localparam logic [31:0] SIG_RST = 32'hFFFF_FFFF;
endpackage

// File: rtl/sata_port_fsm.sv
module sata_port_fsm
    import sata_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic h2d_valid,
    input  logic h2d_ok,
    input  logic srst,
    input  logic clr_busy,
    input  logic comreset,
    output port_st_e state,
    output logic port_rst,
    output logic self_clr,
    output logic cmd_start
);
    port_st_e state_nx;
    logic     accept;

    assign accept = h2d_valid && h2d_ok;

    // next state
    always_comb begin
        state_nx = state;
        if (comreset) begin
            state_nx = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN:   if (accept && srst)  state_nx = ST_RESET;
                ST_RESET: if (accept && !srst) state_nx = ST_RUN;
                default:  state_nx = ST_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        port_rst  = 1'b0;
        self_clr  = 1'b0;
        cmd_start = 1'b0;
        if (comreset) begin
            port_rst = 1'b1;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (accept && srst)  self_clr  = clr_busy;
                    if (accept && !srst) cmd_start = 1'b1;
                end
                ST_RESET: begin
                    if (accept && !srst) port_rst = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sata_port_busy.sv
module sata_port_busy #(
    parameter int NSLOT  = 32,
    parameter int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_rst,
    input  logic              cmd_start,
    input  logic [SLOT_W-1:0] start_slot,
    input  logic              cmd_done,
    output logic              busy_none,
    output logic [SLOT_W-1:0] busy_slot,
    output logic [NSLOT-1:0]  done_mask
);
    logic done_fire;

    assign done_fire = cmd_done && !busy_none;

    for (genvar i = 0; i < NSLOT; i++) begin : g_done
        assign done_mask[i] = done_fire && (busy_slot == SLOT_W'(i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || port_rst) begin
            busy_none <= 1'b1;
            busy_slot <= '1;
        end else if (done_fire) begin
            busy_none <= 1'b1;
            busy_slot <= '1;
        end else if (cmd_start && busy_none) begin
            busy_none <= 1'b0;
            busy_slot <= start_slot;
        end
    end
endmodule

// File: rtl/sata_port_ci_reg.sv
module sata_port_ci_reg #(
    parameter int NSLOT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic [NSLOT-1:0] set_mask,
    input  logic [NSLOT-1:0] clr_mask,
    output logic [NSLOT-1:0] ci
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)  ci[i] <= 1'b0;
            else if (clr_mask[i])   ci[i] <= 1'b0;
            else if (set_mask[i])   ci[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/sata_port_sig_tfd.sv
module sata_port_sig_tfd
    import sata_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_rst,
    input  logic        d2h_valid,
    input  logic [7:0]  d2h_status,
    input  logic [7:0]  d2h_err,
    input  logic [7:0]  d2h_lba_hi,
    input  logic [7:0]  d2h_lba_mid,
    input  logic [7:0]  d2h_sect_num,
    input  logic [7:0]  d2h_sect_cnt,
    output logic [15:0] tfd,
    output logic [31:0] sig,
    output logic        init_d2h_sent
);
    always_ff @(posedge clk) begin
        if (!rst_n || port_rst) begin
            tfd           <= TFD_RST;
            sig           <= SIG_RST;
            init_d2h_sent <= 1'b0;
        end else if (d2h_valid) begin
            tfd <= {d2h_err, d2h_status};
            if (!init_d2h_sent) begin
                init_d2h_sent <= 1'b1;
                sig <= {d2h_lba_hi, d2h_lba_mid, d2h_sect_num, d2h_sect_cnt};
            end
        end
    end
endmodule

// File: rtl/sata_port_tracker.sv
module sata_port_tracker
    import sata_port_pkg::*;
#(
    parameter int NSLOT    = 32,
    parameter int SLOT_W   = $clog2(NSLOT),
    parameter int SRST_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLOT-1:0]  ci_set,
    input  logic              h2d_valid,
    input  logic              h2d_ok,
    input  logic [SLOT_W-1:0] h2d_slot,
    input  logic [7:0]        h2d_ctl,
    input  logic              h2d_clr_busy,
    input  logic              cmd_done,
    input  logic              comreset,
    input  logic              d2h_valid,
    input  logic [7:0]        d2h_status,
    input  logic [7:0]        d2h_err,
    input  logic [7:0]        d2h_lba_hi,
    input  logic [7:0]        d2h_lba_mid,
    input  logic [7:0]        d2h_sect_num,
    input  logic [7:0]        d2h_sect_cnt,
    output logic [NSLOT-1:0]  ci,
    output logic              in_reset,
    output logic [15:0]       tfd,
    output logic [31:0]       sig,
    output logic              busy_none,
    output logic [SLOT_W-1:0] busy_slot,
    output logic              init_d2h_sent
);
    localparam logic [7:0] SRST_MASK = 8'(1 << SRST_BIT);

    port_st_e         state;
    logic             srst;
    logic             port_rst;
    logic             self_clr;
    logic             cmd_start;
    logic [NSLOT-1:0] self_mask;
    logic [NSLOT-1:0] done_mask;
    logic             unused_ctl;

    assign srst       = |(h2d_ctl & SRST_MASK);
    assign unused_ctl = ^(h2d_ctl & ~SRST_MASK);
    assign in_reset   = (state == ST_RESET);

    for (genvar i = 0; i < NSLOT; i++) begin : g_self
        assign self_mask[i] = self_clr && (h2d_slot == SLOT_W'(i));
    end

    sata_port_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .h2d_valid (h2d_valid),
        .h2d_ok    (h2d_ok),
        .srst      (srst),
        .clr_busy  (h2d_clr_busy),
        .comreset  (comreset),
        .state     (state),
        .port_rst  (port_rst),
        .self_clr  (self_clr),
        .cmd_start (cmd_start)
    );

    sata_port_busy #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_rst   (port_rst),
        .cmd_start  (cmd_start),
        .start_slot (h2d_slot),
        .cmd_done   (cmd_done),
        .busy_none  (busy_none),
        .busy_slot  (busy_slot),
        .done_mask  (done_mask)
    );

    sata_port_ci_reg #(.NSLOT(NSLOT)) u_ci (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (port_rst),
        .set_mask (ci_set),
        .clr_mask (self_mask | done_mask),
        .ci       (ci)
    );

    sata_port_sig_tfd u_sig (
        .clk           (clk),
        .rst_n         (rst_n),
        .port_rst      (port_rst),
        .d2h_valid     (d2h_valid),
        .d2h_status    (d2h_status),
        .d2h_err       (d2h_err),
        .d2h_lba_hi    (d2h_lba_hi),
        .d2h_lba_mid   (d2h_lba_mid),
        .d2h_sect_num  (d2h_sect_num),
        .d2h_sect_cnt  (d2h_sect_cnt),
        .tfd           (tfd),
        .sig           (sig),
        .init_d2h_sent (init_d2h_sent)
    );
endmodule

// File: rtl/sata_port_tracker_chk.sv
module sata_port_tracker_chk #(
    parameter int NSLOT    = 32,
    parameter int SLOT_W   = $clog2(NSLOT),
    parameter int SRST_BIT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSLOT-1:0]  ci_set,
    input logic              h2d_valid,
    input logic              h2d_ok,
    input logic [SLOT_W-1:0] h2d_slot,
    input logic [7:0]        h2d_ctl,
    input logic              h2d_clr_busy,
    input logic              cmd_done,
    input logic              comreset,
    input logic              d2h_valid,
    input logic [7:0]        d2h_lba_hi,
    input logic [7:0]        d2h_lba_mid,
    input logic [7:0]        d2h_sect_num,
    input logic [7:0]        d2h_sect_cnt,
    input logic [NSLOT-1:0]  ci,
    input logic              in_reset,
    input logic [15:0]       tfd,
    input logic [31:0]       sig,
    input logic              busy_none,
    input logic [SLOT_W-1:0] busy_slot,
    input logic              init_d2h_sent
);
    logic srst_c;
    logic rel_c;
    assign srst_c = h2d_ctl[SRST_BIT];
    assign rel_c  = in_reset && h2d_valid && h2d_ok && !srst_c;

    p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!comreset && !rel_c && !cmd_done && !(h2d_valid && h2d_ok && srst_c))
        |=> ((ci & $past(ci_set)) == $past(ci_set)) && ((ci & $past(ci)) == $past(ci)));

    p_cmd_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_reset && busy_none && h2d_valid && h2d_ok && !srst_c && !comreset && !cmd_done)
        |=> !busy_none && busy_slot == $past(h2d_slot));

    p_parse_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h2d_valid && !h2d_ok && !comreset && !cmd_done && ci_set == '0)
        |=> ci == $past(ci) && in_reset == $past(in_reset) && busy_none == $past(busy_none));

    p_srst_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_reset && h2d_valid && h2d_ok && srst_c && h2d_clr_busy && !comreset)
        |=> in_reset && !ci[$past(h2d_slot)]);

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_c && !comreset)
        |=> !in_reset && ci == '0 && tfd == 16'h007F && sig == 32'hFFFF_FFFF
            && busy_none && !init_d2h_sent);

    p_comreset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        comreset
        |=> !in_reset && ci == '0 && tfd == 16'h007F && sig == 32'hFFFF_FFFF
            && busy_none && !init_d2h_sent);

    p_first_d2h_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_d2h_sent && d2h_valid && !comreset && !rel_c)
        |=> init_d2h_sent && sig == {$past(d2h_lba_hi), $past(d2h_lba_mid),
                                     $past(d2h_sect_num), $past(d2h_sect_cnt)});

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !busy_none)
        |=> !ci[$past(busy_slot)]);
endmodule

bind sata_port_tracker sata_port_tracker_chk #(
    .NSLOT(NSLOT), .SLOT_W(SLOT_W), .SRST_BIT(SRST_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ci_set(ci_set), .h2d_valid(h2d_valid),
    .h2d_ok(h2d_ok), .h2d_slot(h2d_slot), .h2d_ctl(h2d_ctl),
    .h2d_clr_busy(h2d_clr_busy), .cmd_done(cmd_done), .comreset(comreset),
    .d2h_valid(d2h_valid), .d2h_lba_hi(d2h_lba_hi), .d2h_lba_mid(d2h_lba_mid),
    .d2h_sect_num(d2h_sect_num), .d2h_sect_cnt(d2h_sect_cnt), .ci(ci),
    .in_reset(in_reset), .tfd(tfd), .sig(sig), .busy_none(busy_none),
    .busy_slot(busy_slot), .init_d2h_sent(init_d2h_sent)
);

// File: tb/sata_port_tracker_tb.sv
`timescale 1ns/1ps
module sata_port_tracker_tb;
    localparam int NSLOT = 32;
    localparam int SLOT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSLOT-1:0] ci_set = '0;
    logic h2d_valid = 1'b0, h2d_ok = 1'b0, h2d_clr_busy = 1'b0;
    logic [SLOT_W-1:0] h2d_slot = '0;
    logic [7:0] h2d_ctl = '0;
    logic cmd_done = 1'b0, comreset = 1'b0, d2h_valid = 1'b0;
    logic [7:0] d2h_status = '0, d2h_err = '0, d2h_lba_hi = '0, d2h_lba_mid = '0;
    logic [7:0] d2h_sect_num = '0, d2h_sect_cnt = '0;
    logic [NSLOT-1:0] ci;
    logic in_reset, busy_none, init_d2h_sent;
    logic [15:0] tfd;
    logic [31:0] sig;
    logic [SLOT_W-1:0] busy_slot;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sata_port_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .ci_set(ci_set), .h2d_valid(h2d_valid),
        .h2d_ok(h2d_ok), .h2d_slot(h2d_slot), .h2d_ctl(h2d_ctl),
        .h2d_clr_busy(h2d_clr_busy), .cmd_done(cmd_done), .comreset(comreset),
        .d2h_valid(d2h_valid), .d2h_status(d2h_status), .d2h_err(d2h_err),
        .d2h_lba_hi(d2h_lba_hi), .d2h_lba_mid(d2h_lba_mid),
        .d2h_sect_num(d2h_sect_num), .d2h_sect_cnt(d2h_sect_cnt),
        .ci(ci), .in_reset(in_reset), .tfd(tfd), .sig(sig),
        .busy_none(busy_none), .busy_slot(busy_slot), .init_d2h_sent(init_d2h_sent)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one clock: inputs already driven, outputs sampled at the next falling edge
    task automatic tick();
        @(negedge clk);
        ci_set = '0; h2d_valid = 1'b0; cmd_done = 1'b0;
        comreset = 1'b0; d2h_valid = 1'b0; h2d_clr_busy = 1'b0; h2d_ok = 1'b0;
    endtask

    task automatic fis(input logic [SLOT_W-1:0] s, input logic [7:0] ctl,
                       input logic c, input logic ok);
        h2d_valid = 1'b1; h2d_slot = s; h2d_ctl = ctl; h2d_clr_busy = c; h2d_ok = ok;
    endtask

    task automatic chk_rst_vals(input string req);
        chk(req, "ci", ci, 32'h0);
        chk(req, "tfd", {16'h0, tfd}, 32'h007F);
        chk(req, "sig", sig, 32'hFFFF_FFFF);
        chk(req, "busy_none", {31'h0, busy_none}, 32'h1);
        chk(req, "busy_slot", {27'h0, busy_slot}, 32'h1F);
        chk(req, "init", {31'h0, init_d2h_sent}, 32'h0);
        chk(req, "in_reset", {31'h0, in_reset}, 32'h0);
    endtask

    task automatic t_reset_r9();
        chk_rst_vals("R9");
    endtask

    task automatic t_set_r1();
        ci_set = 32'h8000_0005; tick();
        chk("R1", "ci set", ci, 32'h8000_0005);
        tick();
        chk("R1", "zeros keep", ci, 32'h8000_0005);
        ci_set = 32'h0000_0010; tick();
        chk("R1", "ci or", ci, 32'h8000_0015);
    endtask

    task automatic t_cmd_r2();
        fis(5'd2, 8'h00, 1'b0, 1'b1); tick();
        chk("R2", "busy_none", {31'h0, busy_none}, 32'h0);
        chk("R2", "busy_slot", {27'h0, busy_slot}, 32'h2);
        chk("R2", "ci kept", ci, 32'h8000_0015);
        cmd_done = 1'b1; tick();
        chk("R2", "ci cleared", ci, 32'h8000_0011);
        chk("R2", "busy freed", {31'h0, busy_none}, 32'h1);
    endtask

    task automatic t_parse_r3();
        fis(5'd4, 8'h00, 1'b0, 1'b0); tick();
        chk("R3", "ci", ci, 32'h8000_0011);
        chk("R3", "busy_none", {31'h0, busy_none}, 32'h1);
        fis(5'd4, 8'h04, 1'b1, 1'b0); tick();
        chk("R3", "state", {31'h0, in_reset}, 32'h0);
        chk("R3", "ci after srst", ci, 32'h8000_0011);
    endtask

    task automatic t_prio_r8();
        fis(5'd4, 8'h00, 1'b0, 1'b1); tick();
        cmd_done = 1'b1; ci_set = 32'h0000_0010; tick();
        chk("R8", "clear wins", ci, 32'h8000_0001);
    endtask

    task automatic t_srst_r4_r5();
        fis(5'd0, 8'h04, 1'b1, 1'b1); tick();
        chk("R4", "in_reset", {31'h0, in_reset}, 32'h1);
        chk("R4", "self clear", ci, 32'h8000_0000);
        fis(5'd31, 8'h04, 1'b1, 1'b1); tick();
        chk("R5", "srst ignored state", {31'h0, in_reset}, 32'h1);
        chk("R5", "srst ignored ci", ci, 32'h8000_0000);
        fis(5'd31, 8'h00, 1'b0, 1'b1); ci_set = 32'h0000_0100; tick();
        chk_rst_vals("R5");
        ci_set = 32'h0000_0008; tick();
        fis(5'd3, 8'h04, 1'b0, 1'b1); tick();
        chk("R4", "no C keeps bit", ci, 32'h0000_0008);
        chk("R4", "in_reset noC", {31'h0, in_reset}, 32'h1);
        fis(5'd3, 8'h00, 1'b0, 1'b1); tick();
        chk("R5", "release ci", ci, 32'h0);
    endtask

    task automatic t_d2h_r7();
        d2h_valid = 1'b1; d2h_status = 8'h50; d2h_err = 8'h01;
        d2h_lba_hi = 8'hEB; d2h_lba_mid = 8'h14; d2h_sect_num = 8'h02; d2h_sect_cnt = 8'h03;
        tick();
        chk("R7", "sig", sig, 32'hEB14_0203);
        chk("R7", "tfd", {16'h0, tfd}, 32'h0150);
        chk("R7", "init", {31'h0, init_d2h_sent}, 32'h1);
        d2h_valid = 1'b1; d2h_status = 8'h41; d2h_err = 8'h04; d2h_lba_hi = 8'h96;
        tick();
        chk("R7", "sig held", sig, 32'hEB14_0203);
        chk("R7", "tfd upd", {16'h0, tfd}, 32'h0441);
    endtask

    task automatic t_comreset_r6();
        ci_set = 32'hFF; tick();
        fis(5'd31, 8'h00, 1'b0, 1'b1); tick();
        chk("R6", "busy 31", {27'h0, busy_slot, busy_none}, {26'h0, 5'd31, 1'b0});
        comreset = 1'b1; tick();
        chk_rst_vals("R6");
        fis(5'd1, 8'h04, 1'b0, 1'b1); tick();
        chk("R6", "to reset", {31'h0, in_reset}, 32'h1);
        comreset = 1'b1; tick();
        chk_rst_vals("R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r9();
        t_set_r1();
        t_cmd_r2();
        t_parse_r3();
        t_prio_r8();
        t_srst_r4_r5();
        t_d2h_r7();
        t_comreset_r6();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule